// File: doc/BRIEF.md
# Taxi Fare Meter Core

This block is the counting and charging heart of a taxi meter. While a ride is active it counts distance-unit pulses whenever the cab is moving. It counts minute pulses whenever the cab is standing. It keeps a running fare in decimal (BCD) digits, so a display stage can show it without any conversion. Two tariff sets, day and night, are chosen by a level input. Each set has a base fare that covers a fixed included distance, a per-unit distance rate and a free waiting allowance. After that allowance, each further minute is charged at a rate tied to the tariff.

A surrounding design supplies the already divided distance and minute pulses. It shows the BCD outputs on its own display and drives a lamp from the night indicator. Tariff presets can be written only while the meter is off.

Top module: `taxi_meter_core`

## Requirements
- R1: While `meter_on` is low, distance, waiting time and fare are cleared to zero on the next clock edge, and `past_included` is low.
- R2: On the first clock edge with `meter_on` high after it was low, the fare is loaded with the base fare of the tariff selected by `night_sel` (0 selects day, 1 selects night). After reset the day base is BCD 009 and the night base is BCD 012.
- R3: Each counted distance unit beyond the included 3 units adds the km rate of the current tariff to the fare. After reset the day rate is 3 and the night rate is 4. The fare never decreases during a ride.
- R4: Distance counts one per `dist_tick` only while the cab is running (`waiting` low). It holds while waiting. It is two BCD digits, tens in bits 7:4 and units in bits 3:0, and wraps from 99 to 00.
- R5: Waiting time counts one per `minute_tick` only while waiting, uses the same two-digit BCD layout, and keeps its value when the cab runs again.
- R6: A counted minute is free while the waiting time before it is below the free threshold (3 after reset). Each later minute adds 1 on the day tariff and 2 on the night tariff.
- R7: `past_included` rises together with the distance step past 3 units and stays high until `meter_on` goes low, also across a distance wrap.
- R8: With `preset_we` high and `meter_on` low, the base fare, km rate and free threshold of the tariff picked by `preset_night` are replaced. A write while `meter_on` is high has no effect.
- R9: `night_lamp` equals `night_sel` delayed by one clock.
- R10: The fare is three valid BCD digits (hundreds in bits 11:8). A charge that would pass 999 leaves it at 999.
- R11: A tick in the same cycle as a change of `waiting` is credited to the state in force before the change. The new state takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meter_on | input | 1 | Ride active level; low clears the meter |
| waiting | input | 1 | 1 = cab standing, 0 = cab running |
| night_sel | input | 1 | Tariff select, 1 = night |
| dist_tick | input | 1 | One-cycle distance-unit pulse |
| minute_tick | input | 1 | One-cycle minute pulse |
| preset_we | input | 1 | Tariff preset write strobe |
| preset_night | input | 1 | Tariff set targeted by a preset write |
| preset_base | input | 12 | Preset base fare, three BCD digits |
| preset_km_rate | input | 4 | Preset per-unit distance rate, one BCD digit |
| preset_free_min | input | 8 | Preset free waiting minutes, two BCD digits |
| distance_bcd | output | 8 | Distance, two BCD digits |
| wait_bcd | output | 8 | Waiting time, two BCD digits |
| fare_bcd | output | 12 | Fare, three BCD digits |
| past_included | output | 1 | Included distance exceeded |
| night_lamp | output | 1 | Registered night tariff indicator |

## Verification
Rides are driven on both tariffs with distance pulses up to and past the included distance. This separates the base fare from the per-unit rate and shows which tariff supplies each charge. Minute pulses sent while running, and distance pulses sent while standing, show that each counter listens only in its own state. Pulses that coincide with a state change show which state receives them. Preset writes made while stopped and while running tell an accepted write from an ignored one. A high base with a large rate, plus a hundred-pulse run, reaches fare saturation and the distance wrap.

// File: rtl/taxi_meter_pkg.sv
package taxi_meter_pkg;

   typedef enum logic {
      TARIFF_DAY   = 1'b0,
      TARIFF_NIGHT = 1'b1
   } tariff_e;

   // Binary to packed BCD, eight digits, least significant digit in bits 3:0.
   function automatic logic [31:0] to_bcd(input int unsigned value);
      logic [31:0] r;
      int unsigned v;
      r = '0;
      v = value;
      for (int d = 0; d < 8; d++) begin
         r[4*d +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return r;
   endfunction

endpackage

// File: rtl/tm_bcd_counter.sv
module tm_bcd_counter #(
   parameter int DIGITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                inc,
   output logic [4*DIGITS-1:0] q
);

   logic [DIGITS-1:0] step;

   for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [3:0] dig;

      if (d == 0) begin : g_lsd
         assign step[d] = inc;
      end else begin : g_upper
         assign step[d] = step[d-1] && (q[4*(d-1) +: 4] == 4'd9);
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            dig <= 4'd0;
         end else if (step[d]) begin
            dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
         end
      end

      assign q[4*d +: 4] = dig;
   end

endmodule

// File: rtl/tm_fare_acc.sv
module tm_fare_acc #(
   parameter int DIGITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [4*DIGITS-1:0] load_val,
   input  logic                add,
   input  logic [3:0]          add_val,
   output logic [4*DIGITS-1:0] fare
);

   localparam int W = 4 * DIGITS;

   logic [W-1:0]      fare_r;
   logic [W-1:0]      sum;
   logic [DIGITS:0]   cy;

   assign cy[0] = 1'b0;

   // Ripple decimal adder: binary digit sum, then +6 when it leaves 0..9.
   for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      logic [4:0] raw;
      logic [3:0] adj;
      assign raw = {1'b0, fare_r[4*d +: 4]}
                 + ((d == 0) ? {1'b0, add_val} : 5'd0)
                 + {4'd0, cy[d]};
      assign adj       = raw[3:0] + 4'd6;
      assign cy[d+1]   = (raw > 5'd9);
      assign sum[4*d +: 4] = cy[d+1] ? adj : raw[3:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fare_r <= '0;
      end else if (load) begin
         fare_r <= load_val;
      end else if (add) begin
         fare_r <= cy[DIGITS] ? {DIGITS{4'h9}} : sum;
      end
   end

   assign fare = fare_r;

endmodule

// File: rtl/tm_tariff_bank.sv
module tm_tariff_bank
   import taxi_meter_pkg::*;
#(
   parameter int FARE_DIGITS     = 3,
   parameter int CNT_DIGITS      = 2,
   parameter int DAY_BASE        = 9,
   parameter int NIGHT_BASE      = 12,
   parameter int DAY_KM_RATE     = 3,
   parameter int NIGHT_KM_RATE   = 4,
   parameter int FREE_MINUTES    = 3,
   parameter int DAY_WAIT_RATE   = 1,
   parameter int NIGHT_WAIT_RATE = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_night,
   input  logic [4*FARE_DIGITS-1:0] wr_base,
   input  logic [3:0]               wr_km_rate,
   input  logic [4*CNT_DIGITS-1:0]  wr_free,
   input  logic                     sel_night,
   output logic [4*FARE_DIGITS-1:0] base,
   output logic [3:0]               km_rate,
   output logic [4*CNT_DIGITS-1:0]  free_min,
   output logic [3:0]               wait_rate
);

   localparam int FW = 4 * FARE_DIGITS;
   localparam int CW = 4 * CNT_DIGITS;
   localparam logic [31:0] DAY_BASE_ALL   = to_bcd(DAY_BASE);
   localparam logic [31:0] NIGHT_BASE_ALL = to_bcd(NIGHT_BASE);
   localparam logic [31:0] FREE_ALL       = to_bcd(FREE_MINUTES);
   localparam logic [FW-1:0] DAY_BASE_BCD   = DAY_BASE_ALL[FW-1:0];
   localparam logic [FW-1:0] NIGHT_BASE_BCD = NIGHT_BASE_ALL[FW-1:0];
   localparam logic [CW-1:0] FREE_BCD       = FREE_ALL[CW-1:0];

   logic [FW-1:0] base_r [2];
   logic [3:0]    rate_r [2];
   logic [CW-1:0] free_r [2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_r[TARIFF_DAY]   <= DAY_BASE_BCD;
         base_r[TARIFF_NIGHT] <= NIGHT_BASE_BCD;
         rate_r[TARIFF_DAY]   <= 4'(DAY_KM_RATE);
         rate_r[TARIFF_NIGHT] <= 4'(NIGHT_KM_RATE);
         free_r[TARIFF_DAY]   <= FREE_BCD;
         free_r[TARIFF_NIGHT] <= FREE_BCD;
      end else if (wr_en) begin
         base_r[wr_night] <= wr_base;
         rate_r[wr_night] <= wr_km_rate;
         free_r[wr_night] <= wr_free;
      end
   end

   assign base      = base_r[sel_night];
   assign km_rate   = rate_r[sel_night];
   assign free_min  = free_r[sel_night];
   assign wait_rate = sel_night ? 4'(NIGHT_WAIT_RATE) : 4'(DAY_WAIT_RATE);

endmodule

// File: rtl/taxi_meter_core.sv
module taxi_meter_core
   import taxi_meter_pkg::*;
#(
   parameter int FARE_DIGITS     = 3,
   parameter int CNT_DIGITS      = 2,
   parameter int INCL_UNITS      = 3,
   parameter int DAY_BASE        = 9,
   parameter int NIGHT_BASE      = 12,
   parameter int DAY_KM_RATE     = 3,
   parameter int NIGHT_KM_RATE   = 4,
   parameter int FREE_MINUTES    = 3,
   parameter int DAY_WAIT_RATE   = 1,
   parameter int NIGHT_WAIT_RATE = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     meter_on,
   input  logic                     waiting,
   input  logic                     night_sel,
   input  logic                     dist_tick,
   input  logic                     minute_tick,
   input  logic                     preset_we,
   input  logic                     preset_night,
   input  logic [4*FARE_DIGITS-1:0] preset_base,
   input  logic [3:0]               preset_km_rate,
   input  logic [4*CNT_DIGITS-1:0]  preset_free_min,
   output logic [4*CNT_DIGITS-1:0]  distance_bcd,
   output logic [4*CNT_DIGITS-1:0]  wait_bcd,
   output logic [4*FARE_DIGITS-1:0] fare_bcd,
   output logic                     past_included,
   output logic                     night_lamp
);

   localparam int CW = 4 * CNT_DIGITS;
   localparam int FW = 4 * FARE_DIGITS;
   localparam logic [31:0]   INCL_ALL = to_bcd(INCL_UNITS);
   localparam logic [CW-1:0] INCL_BCD = INCL_ALL[CW-1:0];

   // Elaboration-time parameter checks
   if (FARE_DIGITS < 2 || FARE_DIGITS > 8) begin : g_bad_fare_digits
      $error("FARE_DIGITS must lie in 2..8");
   end
   if (CNT_DIGITS < 1 || CNT_DIGITS > 8) begin : g_bad_cnt_digits
      $error("CNT_DIGITS must lie in 1..8");
   end
   if (DAY_KM_RATE > 9 || NIGHT_KM_RATE > 9 ||
       DAY_WAIT_RATE > 9 || NIGHT_WAIT_RATE > 9) begin : g_bad_rate
      $error("rates are single BCD digits");
   end
   if (INCL_UNITS < 0 || INCL_UNITS >= 10 ** CNT_DIGITS) begin : g_bad_incl
      $error("INCL_UNITS does not fit the distance counter");
   end

   logic on_q, wait_q, lamp_q, over_q, wait_over_q;
   logic start, active, dist_cnt, min_cnt, km_chg, wait_chg;
   logic [FW-1:0] base;
   logic [3:0]    km_rate, wait_rate;
   logic [CW-1:0] free_min;

   assign start    = meter_on && !on_q;
   assign active   = meter_on && on_q;
   // wait_q is last cycle's state, so a tick at a change goes to the old state
   assign dist_cnt = active && !wait_q && dist_tick;
   assign min_cnt  = active &&  wait_q && minute_tick;
   assign km_chg   = dist_cnt && (over_q || distance_bcd >= INCL_BCD);
   assign wait_chg = min_cnt  && (wait_over_q || wait_bcd >= free_min);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q        <= 1'b0;
         wait_q      <= 1'b0;
         lamp_q      <= 1'b0;
         over_q      <= 1'b0;
         wait_over_q <= 1'b0;
      end else begin
         on_q   <= meter_on;
         wait_q <= waiting;
         lamp_q <= night_sel;
         if (!meter_on) begin
            over_q      <= 1'b0;
            wait_over_q <= 1'b0;
         end else begin
            if (km_chg)   over_q      <= 1'b1;
            if (wait_chg) wait_over_q <= 1'b1;
         end
      end
   end

   tm_tariff_bank #(
      .FARE_DIGITS(FARE_DIGITS), .CNT_DIGITS(CNT_DIGITS),
      .DAY_BASE(DAY_BASE), .NIGHT_BASE(NIGHT_BASE),
      .DAY_KM_RATE(DAY_KM_RATE), .NIGHT_KM_RATE(NIGHT_KM_RATE),
      .FREE_MINUTES(FREE_MINUTES),
      .DAY_WAIT_RATE(DAY_WAIT_RATE), .NIGHT_WAIT_RATE(NIGHT_WAIT_RATE)
   ) u_tariffs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(preset_we && !meter_on), .wr_night(preset_night),
      .wr_base(preset_base), .wr_km_rate(preset_km_rate), .wr_free(preset_free_min),
      .sel_night(night_sel),
      .base(base), .km_rate(km_rate), .free_min(free_min), .wait_rate(wait_rate)
   );

   tm_bcd_counter #(.DIGITS(CNT_DIGITS)) u_dist (
      .clk(clk), .rst_n(rst_n), .clr(!meter_on), .inc(dist_cnt), .q(distance_bcd)
   );

   tm_bcd_counter #(.DIGITS(CNT_DIGITS)) u_wait (
      .clk(clk), .rst_n(rst_n), .clr(!meter_on), .inc(min_cnt), .q(wait_bcd)
   );

   tm_fare_acc #(.DIGITS(FARE_DIGITS)) u_fare (
      .clk(clk), .rst_n(rst_n), .clr(!meter_on),
      .load(start), .load_val(base),
      .add(km_chg || wait_chg), .add_val(km_chg ? km_rate : wait_rate),
      .fare(fare_bcd)
   );

   assign past_included = over_q;
   assign night_lamp    = lamp_q;

endmodule

// File: rtl/taxi_meter_chk.sv
module taxi_meter_chk #(
   parameter int FARE_DIGITS = 3,
   parameter int CNT_DIGITS  = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     meter_on,
   input logic                     night_sel,
   input logic                     dist_tick,
   input logic                     minute_tick,
   input logic [4*CNT_DIGITS-1:0]  distance_bcd,
   input logic [4*CNT_DIGITS-1:0]  wait_bcd,
   input logic [4*FARE_DIGITS-1:0] fare_bcd,
   input logic                     past_included,
   input logic                     night_lamp
);

   logic fare_ok;
   always_comb begin
      fare_ok = 1'b1;
      for (int d = 0; d < FARE_DIGITS; d++) begin
         if (fare_bcd[4*d +: 4] > 4'd9) fare_ok = 1'b0;
      end
   end

   // R1
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !meter_on |=> (distance_bcd == '0 && wait_bcd == '0 && fare_bcd == '0 && !past_included));

   // R3
   fare_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meter_on && $past(meter_on) |=> fare_bcd >= $past(fare_bcd));

   // R4
   dist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meter_on && !dist_tick |=> $stable(distance_bcd));

   // R5
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meter_on && !minute_tick |=> $stable(wait_bcd));

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meter_on && past_included |=> past_included);

   // R9
   lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> night_lamp == $past(night_sel));

   // R10
   fare_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n) fare_ok);

endmodule

bind taxi_meter_core taxi_meter_chk #(
   .FARE_DIGITS(FARE_DIGITS), .CNT_DIGITS(CNT_DIGITS)
) u_taxi_meter_chk (.*);

// File: tb/test_taxi_meter_core.sv
module test_taxi_meter_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        meter_on = 1'b0, waiting = 1'b0, night_sel = 1'b0;
   logic        dist_tick = 1'b0, minute_tick = 1'b0;
   logic        preset_we = 1'b0, preset_night = 1'b0;
   logic [11:0] preset_base = '0;
   logic [3:0]  preset_km_rate = '0;
   logic [7:0]  preset_free_min = '0;
   logic [7:0]  distance_bcd, wait_bcd;
   logic [11:0] fare_bcd;
   logic        past_included, night_lamp;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   taxi_meter_core i_taxi_meter_core (
      .clk(clk), .rst_n(rst_n), .meter_on(meter_on), .waiting(waiting),
      .night_sel(night_sel), .dist_tick(dist_tick), .minute_tick(minute_tick),
      .preset_we(preset_we), .preset_night(preset_night), .preset_base(preset_base),
      .preset_km_rate(preset_km_rate), .preset_free_min(preset_free_min),
      .distance_bcd(distance_bcd), .wait_bcd(wait_bcd), .fare_bcd(fare_bcd),
      .past_included(past_included), .night_lamp(night_lamp)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic dist_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         dist_tick = 1'b1; step(); dist_tick = 1'b0;
      end
   endtask

   task automatic minute_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         minute_tick = 1'b1; step(); minute_tick = 1'b0;
      end
   endtask

   task automatic start_ride(input logic night);
      night_sel = night; meter_on = 1'b1; step();
   endtask

   task automatic stop_ride();
      meter_on = 1'b0; waiting = 1'b0; step();
   endtask

   task automatic set_wait(input logic w);
      waiting = w; step();
   endtask

   task automatic preset(input logic night, input logic [11:0] b, input logic [3:0] r,
                         input logic [7:0] f);
      preset_night = night; preset_base = b; preset_km_rate = r; preset_free_min = f;
      preset_we = 1'b1; step(); preset_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "distance after reset", distance_bcd, 'h00);
      chk("R1", "wait after reset", wait_bcd, 'h00);
      chk("R1", "fare after reset", fare_bcd, 'h000);
      chk("R7", "flag after reset", past_included, 0);
      chk("R9", "lamp after reset", night_lamp, 0);
   endtask

   task automatic t_day_ride();
      start_ride(1'b0);
      chk("R2", "day base", fare_bcd, 'h009);
      dist_pulses(3);
      chk("R3", "fare inside included distance", fare_bcd, 'h009);
      chk("R7", "flag at 3 units", past_included, 0);
      dist_pulses(1);
      chk("R4", "distance 4", distance_bcd, 'h04);
      chk("R3", "first charged unit day", fare_bcd, 'h012);
      chk("R7", "flag past included", past_included, 1);
      dist_pulses(2);
      chk("R3", "two more day units", fare_bcd, 'h018);
      set_wait(1'b1);
      dist_pulses(2);
      chk("R4", "distance holds while waiting", distance_bcd, 'h06);
      minute_pulses(3);
      chk("R5", "wait counts", wait_bcd, 'h03);
      chk("R6", "free minutes", fare_bcd, 'h018);
      minute_pulses(2);
      chk("R6", "day wait charge", fare_bcd, 'h020);
      set_wait(1'b0);
      minute_pulses(2);
      chk("R5", "wait kept while running", wait_bcd, 'h05);
      dist_pulses(1);
      chk("R4", "distance resumes", distance_bcd, 'h07);
      chk("R3", "charge after resume", fare_bcd, 'h023);
      stop_ride();
      chk("R1", "distance cleared", distance_bcd, 'h00);
      chk("R1", "wait cleared", wait_bcd, 'h00);
      chk("R1", "fare cleared", fare_bcd, 'h000);
      chk("R7", "flag cleared", past_included, 0);
   endtask

   task automatic t_night_ride();
      start_ride(1'b1);
      chk("R9", "lamp on", night_lamp, 1);
      chk("R2", "night base", fare_bcd, 'h012);
      dist_pulses(4);
      chk("R3", "night km rate", fare_bcd, 'h016);
      set_wait(1'b1);
      minute_pulses(4);
      chk("R6", "night wait rate", fare_bcd, 'h018);
      stop_ride();
      night_sel = 1'b0; step();
      chk("R9", "lamp off", night_lamp, 0);
   endtask

   task automatic t_tick_at_change();
      start_ride(1'b0);
      waiting = 1'b1; dist_tick = 1'b1; step(); dist_tick = 1'b0;
      chk("R11", "distance tick credited to running", distance_bcd, 'h01);
      chk("R11", "wait untouched", wait_bcd, 'h00);
      waiting = 1'b0; minute_tick = 1'b1; step(); minute_tick = 1'b0;
      chk("R11", "minute tick credited to waiting", wait_bcd, 'h01);
      chk("R11", "distance untouched", distance_bcd, 'h01);
      stop_ride();
   endtask

   task automatic t_presets();
      preset(1'b0, 12'h020, 4'd5, 8'h01);
      start_ride(1'b0);
      chk("R8", "preset base", fare_bcd, 'h020);
      dist_pulses(4);
      chk("R8", "preset km rate", fare_bcd, 'h025);
      set_wait(1'b1);
      minute_pulses(2);
      chk("R6", "preset threshold", fare_bcd, 'h026);
      preset(1'b0, 12'h050, 4'd9, 8'h00);
      stop_ride();
      start_ride(1'b0);
      chk("R8", "write while on ignored (base)", fare_bcd, 'h020);
      dist_pulses(4);
      chk("R8", "write while on ignored (rate)", fare_bcd, 'h025);
      stop_ride();
   endtask

   task automatic t_saturate_wrap();
      preset(1'b0, 12'h995, 4'd9, 8'h03);
      start_ride(1'b0);
      chk("R2", "high base", fare_bcd, 'h995);
      dist_pulses(4);
      chk("R10", "saturates", fare_bcd, 'h999);
      dist_pulses(1);
      chk("R10", "stays at max", fare_bcd, 'h999);
      dist_pulses(95);
      chk("R4", "distance wraps", distance_bcd, 'h00);
      chk("R7", "flag survives wrap", past_included, 1);
      chk("R10", "max after wrap", fare_bcd, 'h999);
      stop_ride();
      preset(1'b0, 12'h009, 4'd3, 8'h03);
      start_ride(1'b0);
      chk("R8", "restored base", fare_bcd, 'h009);
      stop_ride();
   endtask

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_day_ride();
      t_night_ride();
      t_tick_at_change();
      t_presets();
      t_saturate_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule